// File: doc/BRIEF.md
# Utility Interrupt Vector Register

This block holds the vector that a local CPU receives when it acknowledges one of up to seven utility interrupts. Software programs a five-bit vector base. The hardware supplies the three low bits. During an acknowledge, the low bits come from the level that the CPU places on its acknowledge address lines. Each utility source is wired to the level that equals its source number, so the returned vector names the source directly.

An ordinary read of the register returns the base with the fixed register offset (binary 001) in the low bits. Software may change the base only while no utility interrupt is pending. A write that arrives while one is pending is refused, and the refusal is reported on a one-cycle error pulse.

All results are registered. They appear on the cycle after the request, together with a one-cycle strobe. When no strobe is raised, the data output is zero.

Top module: `irq_vec_reg`

## Requirements
- R1: After reset, `dout`, `rd_vld`, `ack_vld` and `wr_err` are all 0. A first read then returns 8'h01, because the base has been cleared to zero.
- R2: While `irq_pending` is low, a cycle with `sel` and `wr_en` both high stores `wdata[7:3]` as the base. `wdata[2:0]` is discarded.
- R3: A cycle with `sel` and `rd_en` high and `iack` low gives, on the next cycle, `rd_vld`=1, `ack_vld`=0 and `dout` = base*8 + 1. A write in the same cycle takes effect only on later cycles.
- R4: The first cycle of `sel` and `iack` both high, with `ack_lvl` L in 1..7, gives, on the next cycle, `ack_vld`=1, `rd_vld`=0 and `dout` = base*8 + L.
- R5: An acknowledge with `ack_lvl` = 0 is invalid. On the next cycle `ack_vld`=0 and `dout`=0.
- R6: While `sel` and `iack` stay high over several cycles, `ack_vld` pulses only once, for the first cycle. On the later cycles `dout` is 0.
- R7: A write with `sel`, `wr_en` and `irq_pending` all high leaves the base unchanged. It raises `wr_err` for exactly the next cycle.
- R8: With `sel` low, the inputs `wr_en`, `rd_en` and `iack` have no effect. No strobe is raised and the base is unchanged.
- R9: When `iack` and `rd_en` are high together under `sel`, the acknowledge is served. `rd_vld` stays 0. `rd_vld` and `ack_vld` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Ordinary read request |
| wdata | input | 8 | Write data; bits 7:3 hold the base |
| irq_pending | input | 1 | High while any utility interrupt is pending |
| iack | input | 1 | Interrupt-acknowledge strobe |
| ack_lvl | input | 3 | Acknowledged level, taken from address lines 3:1 |
| dout | output | 8 | Returned vector, or 0 when no strobe is raised |
| rd_vld | output | 1 | One-cycle strobe for a read result |
| ack_vld | output | 1 | One-cycle strobe for an acknowledge vector |
| wr_err | output | 1 | One-cycle pulse for a refused write |

## Verification
If the stored base is corrupted, the fault shows at the ports on the very next read or acknowledge, in bits 7:3 of `dout`. A broken source for the low bits shows up in the same cycle that its strobe rises: either the offset 001 leaks into an acknowledge, or the level leaks into a read. A broken acknowledge edge detector shows as repeated or missing `ack_vld` pulses within two cycles of a held `iack`. A broken write guard shows on the next read after a refused write.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int VEC_W  = 8;
  localparam int LVL_W  = 3;
  localparam int BASE_W = VEC_W - LVL_W;
  localparam logic [LVL_W-1:0] REG_OFFSET = 3'b001;

  // Joins the base and the low field into one vector.
  function automatic logic [VEC_W-1:0] build_vec(input logic [BASE_W-1:0] b,
                                                 input logic [LVL_W-1:0]  low);
    return {b, low};
  endfunction

  // A level of zero names no source.
  function automatic logic lvl_valid(input logic [LVL_W-1:0] l);
    return l != '0;
  endfunction
endpackage

// File: rtl/ivr_base_store.sv
module ivr_base_store
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr_en,
  input  logic              irq_pending,
  input  logic [BASE_W-1:0] wbase,
  output logic [BASE_W-1:0] base,
  output logic              wr_err
);
  logic wr_req, wr_take, wr_block;
  assign wr_req   = sel & wr_en;
  assign wr_take  = wr_req & ~irq_pending;
  assign wr_block = wr_req & irq_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      wr_err <= 1'b0;
    end else begin
      if (wr_take) base <= wbase;
      wr_err <= wr_block;
    end
  end

  // R7: a refused write keeps the base and reports once
  a_r7_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    wr_block |=> ($stable(base) && wr_err));
  // R2: an accepted write lands in the base
  a_r2_base_written: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> (base == $past(wbase) && !wr_err));
endmodule

// File: rtl/ivr_vec_out.sv
module ivr_vec_out
  import irq_vec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              rd_en,
  input  logic              iack,
  input  logic [LVL_W-1:0]  ack_lvl,
  input  logic [BASE_W-1:0] base,
  output logic [VEC_W-1:0]  dout,
  output logic              rd_vld,
  output logic              ack_vld
);
  logic ack_req, ack_prev, ack_edge, ack_take, rd_take;
  logic [VEC_W-1:0] vec_next;

  assign ack_req  = sel & iack;
  assign ack_edge = ack_req & ~ack_prev;
  assign ack_take = ack_edge & lvl_valid(ack_lvl);
  assign rd_take  = sel & rd_en & ~ack_req;

  always_comb begin
    vec_next = '0;
    if (ack_take)     vec_next = build_vec(base, ack_lvl);
    else if (rd_take) vec_next = build_vec(base, REG_OFFSET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_prev <= 1'b0;
      dout     <= '0;
      rd_vld   <= 1'b0;
      ack_vld  <= 1'b0;
    end else begin
      ack_prev <= ack_req;
      dout     <= vec_next;
      rd_vld   <= rd_take;
      ack_vld  <= ack_take;
    end
  end

  // R4: acknowledge vector carries the acknowledged level
  a_r4_level_in_vec: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> (dout[LVL_W-1:0] != '0 && dout[VEC_W-1:LVL_W] == $past(base)));
  // R3: read result carries the register offset
  a_r3_offset_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld |-> dout[LVL_W-1:0] == REG_OFFSET);
  // R6: one strobe per acknowledge
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |=> !ack_vld);
  // R9: strobes exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_vld, ack_vld}));
  // R5: quiet output when no strobe
  a_r5_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_vld && !ack_vld) |-> dout == '0);
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
  import irq_vec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [VEC_W-1:0] wdata,
  input  logic             irq_pending,
  input  logic             iack,
  input  logic [LVL_W-1:0] ack_lvl,
  output logic [VEC_W-1:0] dout,
  output logic             rd_vld,
  output logic             ack_vld,
  output logic             wr_err
);
  logic [BASE_W-1:0] base_w;

  ivr_base_store u_store (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .irq_pending(irq_pending), .wbase(wdata[VEC_W-1:LVL_W]),
    .base(base_w), .wr_err(wr_err)
  );

  ivr_vec_out u_out (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .iack(iack),
    .ack_lvl(ack_lvl), .base(base_w), .dout(dout),
    .rd_vld(rd_vld), .ack_vld(ack_vld)
  );

  // R8: unselected cycles change nothing
  a_r8_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> ($stable(base_w) && !rd_vld && !ack_vld && !wr_err));
endmodule

// File: tb/irq_vec_reg_tb_top.sv
module irq_vec_reg_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, wr_en = 0, rd_en = 0, irq_pending = 0, iack = 0;
  logic [7:0] wdata = 0;
  logic [2:0] ack_lvl = 0;
  logic [7:0] dout;
  logic rd_vld, ack_vld, wr_err;
  int checks = 0, errors = 0;
  int model_base = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vec_reg dut_i (.clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .irq_pending(irq_pending), .iack(iack),
    .ack_lvl(ack_lvl), .dout(dout), .rd_vld(rd_vld), .ack_vld(ack_vld),
    .wr_err(wr_err));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    sel = 0; wr_en = 0; rd_en = 0; iack = 0; ack_lvl = 0; irq_pending = 0;
  endtask

  task automatic do_write(input int v, input bit pend, input bit s);
    sel = s; wr_en = 1; wdata = v[7:0]; irq_pending = pend;
    tick();
    chk(pend && s ? "R7 wr_err" : "R2 wr_err", wr_err, pend && s);
    if (s && !pend) model_base = v / 8;
    idle();
  endtask

  task automatic do_read(input string req);
    sel = 1; rd_en = 1;
    tick();
    chk(req, dout, model_base * 8 + 1);
    chk("R3 rd_vld", rd_vld, 1);
    chk("R9 ack_vld low on read", ack_vld, 0);
    idle();
  endtask

  task automatic do_ack(input int l);
    sel = 1; iack = 1; ack_lvl = l[2:0];
    tick();
    if (l != 0) begin
      chk("R4 vector", dout, model_base * 8 + l);
      chk("R4 ack_vld", ack_vld, 1);
    end else begin
      chk("R5 dout", dout, 0);
      chk("R5 ack_vld", ack_vld, 0);
    end
    chk("R4 rd_vld low", rd_vld, 0);
    idle();
    tick();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1; tick(); tick();
    chk("R1 dout", dout, 0); chk("R1 rd_vld", rd_vld, 0);
    chk("R1 ack_vld", ack_vld, 0); chk("R1 wr_err", wr_err, 0);
    rst_n = 1; tick();
    do_read("R1 reset read");
    // full sweep of bases and levels
    for (int b = 0; b < 32; b++) begin
      do_write(b * 8 + (b % 8), 0, 1);
      do_read("R2 R3 read after write");
      for (int l = 0; l < 8; l++) do_ack(l);
    end
    // R3: write and read in the same cycle return the old base
    do_write(8'h50, 0, 1);
    sel = 1; rd_en = 1; wr_en = 1; wdata = 8'hA8;
    tick();
    chk("R3 same-cycle read", dout, 8'h51);
    model_base = 8'hA8 / 8; idle();
    do_read("R3 later read");
    // R7 refused writes
    for (int v = 0; v < 256; v += 37) begin
      do_write(v, 1, 1);
      tick(); chk("R7 wr_err single", wr_err, 0);
      do_read("R7 base unchanged");
    end
    // R8 unselected
    do_write(8'hF8, 0, 0);
    do_read("R8 write ignored");
    sel = 0; rd_en = 1; iack = 1; ack_lvl = 5;
    tick();
    chk("R8 rd_vld", rd_vld, 0); chk("R8 ack_vld", ack_vld, 0); chk("R8 dout", dout, 0);
    idle(); tick();
    // R6 held acknowledge
    sel = 1; iack = 1; ack_lvl = 6;
    tick(); chk("R6 first", ack_vld, 1); chk("R6 first vec", dout, model_base * 8 + 6);
    tick(); chk("R6 second", ack_vld, 0); chk("R6 second dout", dout, 0);
    tick(); chk("R6 third", ack_vld, 0);
    idle(); tick();
    // R9 acknowledge with read
    sel = 1; iack = 1; rd_en = 1; ack_lvl = 3;
    tick();
    chk("R9 ack_vld", ack_vld, 1); chk("R9 rd_vld", rd_vld, 0);
    chk("R9 vec", dout, model_base * 8 + 3);
    idle(); tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule